// File: doc/BRIEF.md
# Masked-Update Register Bank

This block holds a small bank of control registers. Each register answers at four neighbouring word addresses, and the address chosen sets how a write is applied. One alias loads the write data as it stands. The other three treat the write data as a bit mask and set, clear or invert only the masked bits. Software can therefore change a single control bit in one bus write. It needs no read-modify-write sequence, and no other agent can slip an update in between.

The access port is a word address, one write enable, one read enable and a 32-bit data path. Every access completes in a single cycle. Reads are registered, so the data appears one cycle after the request. All register contents are also driven onto a flat parallel output, which lets the surrounding logic use the control bits directly.

The word address splits into two fields. The low two bits select the alias. The bits above them select the register slot, so registers sit 16 bytes apart in byte terms. Slots at or above the number of implemented registers are holes in the map.

Top module: `alias_reg_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads zero on `regs_q` and `rd_data` is zero.
- R2: A write with alias field `word_addr[1:0]` = 0 replaces the addressed register with `wr_data`.
- R3: A write with alias field 1 ORs `wr_data` into the register. Bits that are 0 in `wr_data` are left unchanged.
- R4: A write with alias field 2 clears each register bit whose `wr_data` bit is 1. All other bits are left unchanged.
- R5: A write with alias field 3 inverts each register bit whose `wr_data` bit is 1. All other bits are left unchanged.
- R6: The register slot is `word_addr[WADDR_W-1:2]`, and register n drives `regs_q[n*32 +: 32]`. A write changes only the register it addresses.
- R7: A write takes effect on the clock edge that samples it. `regs_q` keeps its old value until that edge and shows the new value in the following cycle.
- R8: A read from any of the four aliases returns, one cycle later on `rd_data`, the value the register held at the sampling edge. A write in the same cycle is therefore not yet visible.
- R9: For an unmapped slot (slot index >= NUM_REGS), a write changes no register, and a read returns zero.
- R10: When `rd_en` is low, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write request for this cycle |
| rd_en | input | 1 | Read request for this cycle |
| word_addr | input | WADDR_W (6) | Word address: bits [1:0] select the alias, the bits above select the slot |
| wr_data | input | 32 | Write data, or bit mask for the set, clear and toggle aliases |
| rd_data | output | 32 | Registered read data |
| regs_q | output | NUM_REGS*32 (128) | All register contents, register n at bits [n*32 +: 32] |

## Verification
Directed steps come first:
- One known pattern is loaded through the plain alias. Masks such as 0x0000_00F0 and 0xFFFF_0000 are then applied through the set, clear and toggle aliases. Because a mask overlaps both 1 and 0 bits of the register, the result tells an OR from a replace and a clear from a toggle.
- Reads go through all four aliases, and each must return the same value. A read and a write are issued together to show that the read returns the value from before the write.
- Accesses to unmapped slots must leave every register untouched and must read zero.

A seeded random phase then mixes the four aliases, mapped and unmapped slots, and overlapping reads and writes. The full bank is compared against a bench model after every access.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;

  // Alias field of the word address: how a write is applied.
  typedef enum logic [1:0] {
    ALIAS_LOAD   = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLEAR  = 2'd2,
    ALIAS_TOGGLE = 2'd3
  } alias_op_e;

endpackage

// File: rtl/alias_rst_sync.sv
module alias_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/alias_decode.sv
module alias_decode
  import alias_bank_pkg::*;
#(
  parameter int WADDR_W  = 6,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic [WADDR_W-1:0]  word_addr,
  input  logic                wr_en,
  output alias_op_e           op,
  output logic                hit,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic [IDX_W-1:0]    rd_idx
);

  localparam int SLOT_W = WADDR_W - 2;

  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot   = word_addr[WADDR_W-1:2];
    op     = alias_op_e'(word_addr[1:0]);
    hit    = ({{(32-SLOT_W){1'b0}}, slot} < NUM_REGS);
    rd_idx = slot[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel[g] = wr_en && (slot == SLOT_W'(g));
  end

endmodule

// File: rtl/alias_slot.sv
module alias_slot
  import alias_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] d;

  // Next-state: one of four masked-update forms.
  always_comb begin
    d = q;
    unique case (op)
      ALIAS_LOAD:   d = wdata;
      ALIAS_SET:    d = q | wdata;
      ALIAS_CLEAR:  d = q & ~wdata;
      ALIAS_TOGGLE: d = q ^ wdata;
      default:      d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (sel) begin
      q <= d;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == ALIAS_LOAD) |=> (q == $past(wdata)));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == ALIAS_SET) |=>
      ((q & $past(wdata)) == $past(wdata)) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == ALIAS_CLEAR) |=>
      ((q & $past(wdata)) == '0) && ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == ALIAS_TOGGLE) |=> ((q ^ $past(q)) == $past(wdata)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(q));

endmodule

// File: rtl/alias_read_port.sv
module alias_read_port #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              hit,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] regs [NUM_REGS],
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit && (rd_idx == IDX_W'(i))) begin
        rd_d = regs[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rd_data == '0));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_bank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int WADDR_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [WADDR_W-1:0]         word_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_q
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                rst_sync_n;
  alias_op_e           op;
  logic                hit;
  logic [NUM_REGS-1:0] wr_sel;
  logic [IDX_W-1:0]    rd_idx;
  logic [DATA_W-1:0]   slot_q [NUM_REGS];

  alias_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alias_decode #(
    .WADDR_W  (WADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .word_addr (word_addr),
    .wr_en     (wr_en),
    .op        (op),
    .hit       (hit),
    .wr_sel    (wr_sel),
    .rd_idx    (rd_idx)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    alias_slot #(.DATA_W(DATA_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .sel   (wr_sel[g]),
      .op    (op),
      .wdata (wr_data),
      .q     (slot_q[g])
    );
    assign regs_q[g*DATA_W +: DATA_W] = slot_q[g];
  end

  alias_read_port #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_read (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en),
    .hit     (hit),
    .rd_idx  (rd_idx),
    .regs    (slot_q),
    .rd_data (rd_data)
  );

  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(wr_sel));

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !hit) |=> $stable(regs_q));

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (regs_q == '0 && rd_data == '0));

endmodule

// File: tb/alias_reg_bank_tb_top.sv
`timescale 1ns/1ps
module alias_reg_bank_tb_top;

  localparam int NR = 4;
  localparam int DW = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] word_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NR*DW-1:0] regs_q;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [NR];
  logic [DW-1:0] exp_rd = '0;

  always #2 clk = ~clk;

  alias_reg_bank #(.NUM_REGS(NR), .DATA_W(DW), .WADDR_W(AW)) dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .word_addr (word_addr), .wr_data (wr_data),
    .rd_data (rd_data), .regs_q (regs_q)
  );

  function automatic logic [DW-1:0] apply_op(logic [DW-1:0] old, logic [1:0] op, logic [DW-1:0] m);
    case (op)
      2'd0: return m;
      2'd1: return old | m;
      2'd2: return old & ~m;
      default: return old ^ m;
    endcase
  endfunction

  function automatic logic [NR*DW-1:0] pack_model();
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = model[i];
    return v;
  endfunction

  task automatic check_eq(input string req, input logic [NR*DW-1:0] act, input logic [NR*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; checks regs_q and rd_data in the cycle after the sampling edge.
  task automatic access(input bit we, input bit re, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string req);
    int slot;
    @(negedge clk);
    wr_en = we; rd_en = re; word_addr = a; wr_data = d;
    slot = int'(a[AW-1:2]);
    if (re) exp_rd = (slot < NR) ? model[slot] : '0;
    if (we && slot < NR) model[slot] = apply_op(model[slot], a[1:0], d);
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    check_eq({req, " regs"}, regs_q, pack_model());
    check_eq({req, " rd_data"}, {{(NR-1)*DW{1'b0}}, rd_data}, {{(NR-1)*DW{1'b0}}, exp_rd});
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE5));
    for (int i = 0; i < NR; i++) model[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check_eq("R1 in reset", regs_q, '0);
    check_eq("R1 rd_data in reset", {{(NR-1)*DW{1'b0}}, rd_data}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 after release", regs_q, '0);

    // R2 load, R7 timing
    @(negedge clk);
    wr_en = 1'b1; word_addr = {4'd0, 2'd0}; wr_data = 32'hA5A5_F00F;
    #1;
    check_eq("R7 before edge", regs_q, '0);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model[0] = 32'hA5A5_F00F;
    @(negedge clk);
    check_eq("R7 after edge", regs_q, pack_model());
    access(1, 0, {4'd0, 2'd0}, 32'h1234_5678, "R2 load");
    access(1, 0, {4'd0, 2'd1}, 32'h0000_00F0, "R3 set");
    access(1, 0, {4'd0, 2'd2}, 32'hFFFF_0000, "R4 clear");
    access(1, 0, {4'd0, 2'd3}, 32'h00FF_00FF, "R5 toggle");
    access(1, 0, {4'd2, 2'd0}, 32'hDEAD_BEEF, "R6 slot2 only");
    access(1, 0, {4'd3, 2'd1}, 32'h8000_0001, "R6 slot3 set");
    for (int al = 0; al < 4; al++)
      access(0, 1, {4'd2, 2'(al)}, '0, "R8 read alias");
    access(1, 1, {4'd2, 2'd3}, 32'hFFFF_FFFF, "R8 read old on same-cycle write");
    access(0, 0, {4'd1, 2'd0}, '0, "R10 rd_data holds");
    access(1, 0, {4'd9, 2'd0}, 32'hFFFF_FFFF, "R9 unmapped write");
    access(1, 0, {4'd15, 2'd1}, 32'hFFFF_FFFF, "R9 unmapped set");
    access(0, 1, {4'd9, 2'd0}, '0, "R9 unmapped read");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] s;
      logic [1:0] al;
      bit we, re;
      s  = ($urandom_range(0, 4) == 0) ? 4'($urandom_range(NR, 15)) : 4'($urandom_range(0, NR-1));
      al = 2'($urandom_range(0, 3));
      we = ($urandom_range(0, 2) != 0);
      re = ($urandom_range(0, 1) != 0);
      access(we, re, {s, al}, $urandom(), "R2-R10 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule